// File: doc/BRIEF.md
# Chip-Select Gated Duplicating Command Register

This block is a one-stage register for a memory address and command bus. It samples a data word, the two active-low chip-select lines, two clock-enable lines and two on-die-termination lines on the rising clock edge. Each registered value is driven out as two identical copies, named A and B, so that two loads can be served from one register stage.

A gate-enable input sets how the data word is captured. When gate-enable is high, the data word is captured only on an edge at which a chip select is active. When gate-enable is low, the data word is captured on every edge. The chip-select, clock-enable and termination lines are registered on every edge in both modes.

An asynchronous active-low reset clears every output at once. A two-state controller (HELD, RUN) handles the release from reset. Reset forces HELD. The transition named *release* moves HELD to RUN on the first rising edge with reset high, and no capture takes place on that edge. RUN then loops on itself through the transition named *stay*.

Top module: `rbuf_cs_gated`

## Requirements
- R1: Each registered value appears on its A output and its B output, and the two copies are always equal.
- R2: With `gate_en` high and both bits of `cs_n_in` high, a rising edge leaves `q_a`/`q_b` unchanged.
- R3: With `gate_en` high and at least one bit of `cs_n_in` low (chip selects are active low; bit 0 is select 0), `q_a`/`q_b` take the value of `d_in` sampled at that rising edge.
- R4: With `gate_en` low, `q_a`/`q_b` take `d_in` on every rising edge, whatever `cs_n_in` is.
- R5: `cke_a/b` and `odt_a/b` take `cke_in` and `odt_in` on every rising edge in RUN, independent of `gate_en` and the chip selects.
- R6: `cs_a/b` take `cs_n_in` on every rising edge in RUN, including edges at which the data word is held.
- R7: Driving `rst_n` low forces every output to zero immediately, with no clock edge, and this overrides chip-select gating.
- R8: After `rst_n` rises, the first rising edge captures nothing and all outputs stay zero. Capture begins on the second rising edge.
- R9: Outputs change only at rising clock edges. An input change between edges does not reach the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en | input | 1 | 1: capture the data word only when a chip select is low; 0: capture on every edge |
| cs_n_in | input | 2 | Active-low chip selects |
| cke_in | input | 2 | Clock-enable lines |
| odt_in | input | 2 | Termination lines |
| d_in | input | 22 | Address/command data word |
| q_a | output | 22 | Data copy A |
| q_b | output | 22 | Data copy B |
| cs_a | output | 2 | Chip-select copy A |
| cs_b | output | 2 | Chip-select copy B |
| cke_a | output | 2 | Clock-enable copy A |
| cke_b | output | 2 | Clock-enable copy B |
| odt_a | output | 2 | Termination copy A |
| odt_b | output | 2 | Termination copy B |

## Verification
The bench targets edges at which both selects are high with gating on. A design that ignored the gate would load a new word there, and a design that also froze the side-band lines would leave `cke`, `odt` or the select copies stale. It drives `gate_en` low with both selects high to catch a design that gates in both modes. It asserts reset in mid-cycle, where a synchronous reset would leave stale outputs until the next edge. It checks the first edge after release, where a design without the HELD state would capture one cycle early. It also changes inputs between edges, which exposes any combinational path to the outputs.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;

    typedef enum logic {
        CTL_HELD = 1'b0,
        CTL_RUN  = 1'b1
    } ctl_state_e;

    localparam int unsigned COPIES = 2;

endpackage

// File: rtl/rbuf_ctrl.sv
module rbuf_ctrl
    import rbuf_pkg::*;
#(
    parameter int unsigned CSW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           gate_en,
    input  logic [CSW-1:0] cs_n,
    output logic           run,
    output logic           side_load,
    output logic           data_load
);

    ctl_state_e state_q;
    ctl_state_e state_d;
    logic       any_cs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CTL_HELD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_HELD: state_d = CTL_RUN;   // release
            CTL_RUN:  state_d = CTL_RUN;   // stay
        endcase
    end

    always_comb begin
        any_cs    = ~(&cs_n);
        run       = (state_q == CTL_RUN);
        side_load = run;
        data_load = run && (!gate_en || any_cs);
    end

    // R8: the release edge itself never loads anything
    p_release_no_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTL_HELD) |-> (!data_load && !side_load));

endmodule

// File: rtl/rbuf_dup_reg.sv
module rbuf_dup_reg
    import rbuf_pkg::*;
#(
    parameter int unsigned W = 22
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] qa,
    output logic [W-1:0] qb
);

    logic [W-1:0] copy_q [COPIES];

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                copy_q[c] <= '0;
            end else if (load) begin
                copy_q[c] <= din;
            end
        end
    end

    assign qa = copy_q[0];
    assign qb = copy_q[1];

    // R9: nothing moves without a load edge
    p_hold_without_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(qa) && $stable(qb));

endmodule

// File: rtl/rbuf_cs_gated.sv
module rbuf_cs_gated #(
    parameter int unsigned DW  = 22,
    parameter int unsigned CSW = 2,
    parameter int unsigned CKW = 2,
    parameter int unsigned OTW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           gate_en,
    input  logic [CSW-1:0] cs_n_in,
    input  logic [CKW-1:0] cke_in,
    input  logic [OTW-1:0] odt_in,
    input  logic [DW-1:0]  d_in,
    output logic [DW-1:0]  q_a,
    output logic [DW-1:0]  q_b,
    output logic [CSW-1:0] cs_a,
    output logic [CSW-1:0] cs_b,
    output logic [CKW-1:0] cke_a,
    output logic [CKW-1:0] cke_b,
    output logic [OTW-1:0] odt_a,
    output logic [OTW-1:0] odt_b
);

    logic run;
    logic side_load;
    logic data_load;

    rbuf_ctrl #(.CSW(CSW)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_en   (gate_en),
        .cs_n      (cs_n_in),
        .run       (run),
        .side_load (side_load),
        .data_load (data_load)
    );

    rbuf_dup_reg #(.W(DW)) i_data (
        .clk(clk), .rst_n(rst_n), .load(data_load),
        .din(d_in), .qa(q_a), .qb(q_b)
    );

    rbuf_dup_reg #(.W(CSW)) i_cs (
        .clk(clk), .rst_n(rst_n), .load(side_load),
        .din(cs_n_in), .qa(cs_a), .qb(cs_b)
    );

    rbuf_dup_reg #(.W(CKW)) i_cke (
        .clk(clk), .rst_n(rst_n), .load(side_load),
        .din(cke_in), .qa(cke_a), .qb(cke_b)
    );

    rbuf_dup_reg #(.W(OTW)) i_odt (
        .clk(clk), .rst_n(rst_n), .load(side_load),
        .din(odt_in), .qa(odt_a), .qb(odt_b)
    );

    p_copies_equal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q_a == q_b) && (cs_a == cs_b) && (cke_a == cke_b) && (odt_a == odt_b));

    p_gate_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && gate_en && (&cs_n_in)) |=> $stable(q_a));

    p_gate_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && gate_en && !(&cs_n_in)) |=> (q_a == $past(d_in)));

    p_ungated_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !gate_en) |=> (q_a == $past(d_in)));

    p_side_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (cke_a == $past(cke_in)) && (odt_a == $past(odt_in)));

    p_cs_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (cs_a == $past(cs_n_in)));

    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |-> (q_a == '0) && (cs_a == '0) && (cke_a == '0) && (odt_a == '0));

    p_release_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (q_a == '0) && (cs_a == '0) && (cke_a == '0) && (odt_a == '0));

endmodule

// File: tb/test_rbuf_cs_gated.sv
module test_rbuf_cs_gated;

    localparam time CLK_PERIOD = 10ns;
    localparam int  DW = 22;
    localparam int  NV = 10;

    typedef struct packed {
        logic          g;
        logic [1:0]    cs;
        logic [1:0]    cke;
        logic [1:0]    odt;
        logic [DW-1:0] d;
    } vec_t;

    // R2/R3/R4/R5/R6 patterns
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'b10, 2'b01, 2'b10, 22'h2AAAAA},
        '{1'b1, 2'b11, 2'b10, 2'b01, 22'h155555},
        '{1'b1, 2'b01, 2'b11, 2'b00, 22'h0F0F0F},
        '{1'b1, 2'b11, 2'b00, 2'b11, 22'h3FFFFF},
        '{1'b1, 2'b00, 2'b01, 2'b01, 22'h000001},
        '{1'b0, 2'b11, 2'b10, 2'b10, 22'h123456},
        '{1'b0, 2'b11, 2'b01, 2'b00, 22'h200000},
        '{1'b0, 2'b10, 2'b11, 2'b11, 22'h0ABCDE},
        '{1'b1, 2'b11, 2'b00, 2'b10, 22'h3C3C3C},
        '{1'b1, 2'b11, 2'b11, 2'b01, 22'h111111}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          gate_en;
    logic [1:0]    cs_n_in, cke_in, odt_in;
    logic [DW-1:0] d_in;
    logic [DW-1:0] q_a, q_b;
    logic [1:0]    cs_a, cs_b, cke_a, cke_b, odt_a, odt_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DW-1:0] mq;
    logic [1:0]    mcs, mcke, modt;

    always #(CLK_PERIOD/2) clk = ~clk;

    rbuf_cs_gated i_rbuf_cs_gated (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_en),
        .cs_n_in(cs_n_in), .cke_in(cke_in), .odt_in(odt_in), .d_in(d_in),
        .q_a(q_a), .q_b(q_b), .cs_a(cs_a), .cs_b(cs_b),
        .cke_a(cke_a), .cke_b(cke_b), .odt_a(odt_a), .odt_b(odt_b)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " q_a"},   32'(q_a),   32'(mq));
        check({tag, " q_b R1"}, 32'(q_b),  32'(mq));
        check({tag, " cs_a R6"}, 32'(cs_a), 32'(mcs));
        check({tag, " cs_b R1"}, 32'(cs_b), 32'(mcs));
        check({tag, " cke_a R5"}, 32'(cke_a), 32'(mcke));
        check({tag, " cke_b R1"}, 32'(cke_b), 32'(mcke));
        check({tag, " odt_a R5"}, 32'(odt_a), 32'(modt));
        check({tag, " odt_b R1"}, 32'(odt_b), 32'(modt));
    endtask

    task automatic drive(input vec_t v);
        gate_en = v.g; cs_n_in = v.cs; cke_in = v.cke; odt_in = v.odt; d_in = v.d;
    endtask

    initial begin
        rst_n = 1'b0;
        drive('{1'b1, 2'b00, 2'b11, 2'b11, 22'h3FFFFF});
        mq = '0; mcs = '0; mcke = '0; modt = '0;
        #2;
        check_all("R7 reset at time zero");

        // release at a falling edge
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check_all("R8 first edge after release");

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(posedge clk); #1;
            mcs = VECS[i].cs; mcke = VECS[i].cke; modt = VECS[i].odt;
            if (!VECS[i].g || !(&VECS[i].cs)) mq = VECS[i].d;
            check_all($sformatf("R2 R3 R4 vector %0d", i));
        end

        // R9: mid-cycle input change does not reach outputs
        @(negedge clk);
        drive('{1'b0, 2'b01, 2'b10, 2'b01, 22'h0C0FFE});
        @(posedge clk); #1;
        mq = 22'h0C0FFE; mcs = 2'b01; mcke = 2'b10; modt = 2'b01;
        check_all("R4 before mid-cycle change");
        #2;
        drive('{1'b0, 2'b10, 2'b01, 2'b10, 22'h3A5A5A});
        #1;
        check_all("R9 mid-cycle change");

        // R7: mid-cycle reset while gated hold is selected
        @(negedge clk);
        drive('{1'b1, 2'b11, 2'b11, 2'b11, 22'h3FFFFF});
        #1;
        rst_n = 1'b0;
        #1;
        mq = '0; mcs = '0; mcke = '0; modt = '0;
        check_all("R7 asynchronous clear");
        @(posedge clk); #1;
        check_all("R7 reset held over edge");

        // R8 again: release, quiet edge, then capture
        @(negedge clk);
        drive('{1'b0, 2'b10, 2'b01, 2'b11, 22'h055AA5});
        rst_n = 1'b1;
        @(posedge clk); #1;
        check_all("R8 quiet edge after second release");
        @(posedge clk); #1;
        mq = 22'h055AA5; mcs = 2'b10; mcke = 2'b01; modt = 2'b11;
        check_all("R8 second edge captures");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule